// File: doc/BRIEF.md
# Boot-Overlay Memory Decoder

This block sits between a 16-bit CPU bus and one shared static RAM of two 16-bit banks. It decodes each CPU word address into one of four windows: chip RAM, fast RAM, the system ROM image held in RAM, and the slow peripheral-chip window. It then drives the bank enables, the word address, the byte enables and the write and output enables of the RAM. It returns one acknowledge per access, and the read data is latched in the cycle of that acknowledge.

After a power-on reset a small computed boot ROM covers the lowest 512 bytes. A loader input records that the boot stage has finished. The overlay disappears only on the next CPU-issued reset after that. A second loader input locks the ROM-image window against writes; reads from it continue. Neither flag is cleared by a CPU-issued reset. Accesses to the peripheral window are held for ten bus clocks, so the peripherals see roughly one tenth of the bus rate. There are no tri-states: every source that is not selected contributes zeros to an OR-combined read bus.

Top module: `boot_mem_decoder`

## Requirements
- R1: Word address A (byte address a = 2·A) maps as follows. Chip RAM covers a in 0x000000–0x07FFFF at physical word A. Fast RAM covers 0x200000–0x2FFFFF at physical word 0x40000 + (a−0x200000)/2. The ROM image covers 0xF80000–0xFFFFFF at physical word 0xC0000 + (a−0xF80000)/2. Physical word bit 19 selects the bank (ram_bank_en bit 0 for bank 0, bit 1 for bank 1), and ram_addr carries physical word bits 18:0.
- R2: During a RAM access, ram_ube follows cpu_uds (bits 15:8) and ram_lbe follows cpu_lds (bits 7:0).
- R3: A request outside the peripheral window is acknowledged at the first rising edge that samples it. The RAM write enable lasts exactly one cycle, and a read returns the RAM word presented in that cycle.
- R4: After a power-on reset, word reads with a below 0x000200 return 0xB000 + a/2 and raise neither ram_oe nor ram_we. Writes to that range do not reach the RAM.
- R5: The overlay is removed only by a cpu_rst pulse that arrives after ldr_boot_set has been pulsed. A cpu_rst pulse before that point, or ldr_boot_set on its own, leaves it in place.
- R6: Once ldr_lock_set has been pulsed, writes to the ROM-image window are acknowledged but raise no ram_we. Reads from the window are unaffected.
- R7: The write lock and the boot-done flag survive cpu_rst. Only a power-on reset (rst_por_n low) clears them and brings the overlay back.
- R8: A request in the peripheral window (a in 0xBF0000–0xBFFFFF) raises per_sel, and per_we for writes. It is acknowledged on the tenth rising edge that samples the request, and a read returns per_rdata.
- R9: Each acknowledge is a single-cycle pulse. No second acknowledge comes before the request drops, and every peripheral access, including one that follows another directly, waits the full ten clocks.
- R10: cpu_rdata is zero whenever cpu_ack is low. A request to an unmapped address is acknowledged after one edge, returns zero and drives no RAM or peripheral strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_por_n | input | 1 | Power-on reset, active low, synchronous |
| cpu_rst | input | 1 | CPU-issued reset, active high, synchronous |
| ldr_lock_set | input | 1 | Loader pulse: lock the ROM-image window |
| ldr_boot_set | input | 1 | Loader pulse: boot stage finished |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_uds | input | 1 | Upper data strobe |
| cpu_lds | input | 1 | Lower data strobe |
| cpu_addr | input | 23 | CPU word address (byte address bits 23:1) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ack | output | 1 | Access acknowledge, one-cycle pulse |
| cpu_rdata | output | 16 | Read data, valid with cpu_ack, zero otherwise |
| ram_bank_en | output | 2 | Per-bank chip enable |
| ram_addr | output | 19 | Word address within a bank |
| ram_ube | output | 1 | Upper byte enable |
| ram_lbe | output | 1 | Lower byte enable |
| ram_oe | output | 1 | RAM output enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 16 | RAM write data, zero when not writing |
| ram_rdata | input | 16 | RAM read data |
| per_sel | output | 1 | Peripheral window select |
| per_we | output | 1 | Peripheral write |
| per_wdata | output | 16 | Peripheral write data, zero when not writing |
| per_rdata | input | 16 | Peripheral read data |

## Verification
Addresses are taken at the low and high ends of each window, so an off-by-one base or a wrong bank bit shows up as a mismatch between the pin values and the word read back. Byte-strobe writes with only one strobe set separate the upper and lower enables. The same address zero is read under all flag combinations: fresh power-on, CPU reset without boot-done, boot-done without reset, and both. This separates overlay removal from each trigger alone. Peripheral accesses issued directly after each other, together with ROM-image writes before and after the lock and across both reset kinds, cover the counter restart and the persistence of the flags.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

    parameter int WORD_AW  = 23;   // CPU word address width
    parameter int PHYS_AW  = 20;   // physical word address over all banks
    parameter int DATA_W   = 16;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CHIP,
        RG_FAST,
        RG_KICK,
        RG_PERI,
        RG_BOOT
    } region_e;

    typedef struct packed {
        region_e              region;
        logic [PHYS_AW-1:0]   phys;
    } decode_t;

    typedef enum logic [1:0] {
        AC_IDLE,
        AC_STRETCH,
        AC_DONE
    } acc_state_e;

endpackage

// File: rtl/mem_region_decode.sv
module mem_region_decode
    import memdec_pkg::*;
#(
    parameter int unsigned BOOT_AW   = 8,
    parameter logic [WORD_AW-1:0] CHIP_BASE = 23'h000000,
    parameter logic [WORD_AW-1:0] CHIP_SIZE = 23'h040000,
    parameter logic [WORD_AW-1:0] FAST_BASE = 23'h100000,
    parameter logic [WORD_AW-1:0] FAST_SIZE = 23'h080000,
    parameter logic [WORD_AW-1:0] KICK_BASE = 23'h7C0000,
    parameter logic [WORD_AW-1:0] KICK_SIZE = 23'h040000,
    parameter logic [WORD_AW-1:0] PERI_BASE = 23'h5F8000,
    parameter logic [WORD_AW-1:0] PERI_SIZE = 23'h008000,
    parameter logic [PHYS_AW-1:0] CHIP_PHYS = 20'h00000,
    parameter logic [PHYS_AW-1:0] FAST_PHYS = 20'h40000,
    parameter logic [PHYS_AW-1:0] KICK_PHYS = 20'hC0000
) (
    input  logic [WORD_AW-1:0] word_addr,
    input  logic               overlay,
    output decode_t            dec
);

    localparam int NREG = 4;
    localparam logic [WORD_AW-1:0] BOOT_WORDS = WORD_AW'(1) << BOOT_AW;
    localparam logic [WORD_AW-1:0] BASES [NREG] = '{CHIP_BASE, FAST_BASE, KICK_BASE, PERI_BASE};
    localparam logic [WORD_AW-1:0] SIZES [NREG] = '{CHIP_SIZE, FAST_SIZE, KICK_SIZE, PERI_SIZE};
    localparam logic [PHYS_AW-1:0] POFFS [NREG] = '{CHIP_PHYS, FAST_PHYS, KICK_PHYS, '0};
    localparam region_e            CODES [NREG] = '{RG_CHIP, RG_FAST, RG_KICK, RG_PERI};

    logic [WORD_AW-1:0] off [NREG];

    always_comb begin
        dec.region = RG_NONE;
        dec.phys   = '0;
        for (int i = 0; i < NREG; i++) begin
            off[i] = word_addr - BASES[i];
            if (dec.region == RG_NONE && off[i] < SIZES[i]) begin
                dec.region = CODES[i];
                dec.phys   = POFFS[i] + off[i][PHYS_AW-1:0];
            end
        end
        // boot overlay takes priority over the chip window it covers
        if (overlay && word_addr < BOOT_WORDS) begin
            dec.region = RG_BOOT;
            dec.phys   = '0;
        end
    end

endmodule

// File: rtl/boot_rom.sv
module boot_rom
    import memdec_pkg::*;
#(
    parameter int unsigned BOOT_AW  = 8,
    parameter logic [7:0]  BOOT_TAG = 8'hB0
) (
    input  logic [BOOT_AW-1:0] idx,
    output logic [DATA_W-1:0]  word
);

    // contents are computed: a tag in the upper byte, the word index below
    always_comb begin
        word = (DATA_W'(BOOT_TAG) << 8) | DATA_W'(idx);
    end

endmodule

// File: rtl/access_ctl.sv
module access_ctl
    import memdec_pkg::*;
#(
    parameter int unsigned PER_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              cpu_rst,
    input  logic              ldr_lock_set,
    input  logic              ldr_boot_set,
    input  logic              cpu_req,
    input  logic              is_peri,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              lock,
    output logic              overlay,
    output logic              idle,
    output logic              stretching
);

    localparam int CW = $clog2(PER_DIV + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PER_DIV - 1);

    typedef struct packed {
        acc_state_e         st;
        logic [CW-1:0]      cnt;
        logic               ack;
        logic [DATA_W-1:0]  rdata;
        logic               lock;
        logic               boot_done;
        logic               overlay;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st: AC_IDLE, cnt: '0, ack: 1'b0, rdata: '0,
        lock: 1'b0, boot_done: 1'b0, overlay: 1'b1
    };

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ack   = 1'b0;
        ctl_d.rdata = '0;
        if (ldr_lock_set) ctl_d.lock = 1'b1;
        if (ldr_boot_set) ctl_d.boot_done = 1'b1;

        unique case (ctl_q.st)
            AC_IDLE: begin
                if (cpu_req) begin
                    if (is_peri) begin
                        ctl_d.st  = AC_STRETCH;
                        ctl_d.cnt = CW'(1);
                    end else begin
                        ctl_d.st    = AC_DONE;
                        ctl_d.ack   = 1'b1;
                        ctl_d.rdata = bus_rdata;
                    end
                end
            end
            AC_STRETCH: begin
                if (!cpu_req) begin
                    ctl_d.st  = AC_IDLE;
                    ctl_d.cnt = '0;
                end else if (ctl_q.cnt == CNT_LAST) begin
                    ctl_d.st    = AC_DONE;
                    ctl_d.cnt   = '0;
                    ctl_d.ack   = 1'b1;
                    ctl_d.rdata = bus_rdata;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                end
            end
            AC_DONE: begin
                if (!cpu_req) ctl_d.st = AC_IDLE;
            end
            default: ctl_d.st = AC_IDLE;
        endcase

        if (cpu_rst) begin
            ctl_d.st    = AC_IDLE;
            ctl_d.cnt   = '0;
            ctl_d.ack   = 1'b0;
            ctl_d.rdata = '0;
            if (ctl_q.boot_done) ctl_d.overlay = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_por_n) ctl_q <= CTL_RESET;
        else            ctl_q <= ctl_d;
    end

    always_comb begin
        ack        = ctl_q.ack;
        rdata      = ctl_q.rdata;
        lock       = ctl_q.lock;
        overlay    = ctl_q.overlay;
        idle       = (ctl_q.st == AC_IDLE);
        stretching = (ctl_q.st == AC_STRETCH);
    end

endmodule

// File: rtl/boot_mem_decoder.sv
module boot_mem_decoder
    import memdec_pkg::*;
#(
    parameter int unsigned PER_DIV  = 10,
    parameter int unsigned BOOT_AW  = 8,
    parameter int unsigned NBANK    = 2,
    localparam int BANK_AW = PHYS_AW - $clog2(NBANK)
) (
    input  logic                clk,
    input  logic                rst_por_n,
    input  logic                cpu_rst,
    input  logic                ldr_lock_set,
    input  logic                ldr_boot_set,
    input  logic                cpu_req,
    input  logic                cpu_rw,
    input  logic                cpu_uds,
    input  logic                cpu_lds,
    input  logic [WORD_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_ack,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic [NBANK-1:0]    ram_bank_en,
    output logic [BANK_AW-1:0]  ram_addr,
    output logic                ram_ube,
    output logic                ram_lbe,
    output logic                ram_oe,
    output logic                ram_we,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                per_sel,
    output logic                per_we,
    output logic [DATA_W-1:0]   per_wdata,
    input  logic [DATA_W-1:0]   per_rdata
);

    localparam int BSEL_W = PHYS_AW - BANK_AW;

    decode_t            dec;
    logic [DATA_W-1:0]  rom_word;
    logic [DATA_W-1:0]  bus_rdata;
    logic               lock_w;
    logic               overlay_w;
    logic               idle_w;
    logic               stretch_w;
    logic               access_ok;
    logic               ram_hit;
    logic               ram_act;
    logic [BSEL_W-1:0]  bank_idx;

    mem_region_decode #(
        .BOOT_AW (BOOT_AW)
    ) u_decode (
        .word_addr (cpu_addr),
        .overlay   (overlay_w),
        .dec       (dec)
    );

    boot_rom #(
        .BOOT_AW (BOOT_AW)
    ) u_boot_rom (
        .idx  (cpu_addr[BOOT_AW-1:0]),
        .word (rom_word)
    );

    access_ctl #(
        .PER_DIV (PER_DIV)
    ) u_ctl (
        .clk          (clk),
        .rst_por_n    (rst_por_n),
        .cpu_rst      (cpu_rst),
        .ldr_lock_set (ldr_lock_set),
        .ldr_boot_set (ldr_boot_set),
        .cpu_req      (cpu_req),
        .is_peri      (dec.region == RG_PERI),
        .bus_rdata    (bus_rdata),
        .ack          (cpu_ack),
        .rdata        (cpu_rdata),
        .lock         (lock_w),
        .overlay      (overlay_w),
        .idle         (idle_w),
        .stretching   (stretch_w)
    );

    always_comb begin
        access_ok = cpu_req && idle_w;
        ram_hit   = (dec.region == RG_CHIP) || (dec.region == RG_FAST) ||
                    (dec.region == RG_KICK);
        bank_idx  = dec.phys[PHYS_AW-1:BANK_AW];

        ram_oe    = access_ok && ram_hit && cpu_rw;
        ram_we    = access_ok && ram_hit && !cpu_rw &&
                    !((dec.region == RG_KICK) && lock_w);
        ram_act   = ram_oe || ram_we;
        ram_addr  = dec.phys[BANK_AW-1:0];
        ram_ube   = ram_act && cpu_uds;
        ram_lbe   = ram_act && cpu_lds;
        ram_wdata = ram_we ? cpu_wdata : '0;

        per_sel   = cpu_req && (dec.region == RG_PERI) && (idle_w || stretch_w);
        per_we    = per_sel && !cpu_rw;
        per_wdata = per_we ? cpu_wdata : '0;

        // OR-combined read bus: unselected sources contribute zero
        bus_rdata = (ram_oe ? ram_rdata : '0) |
                    ((dec.region == RG_BOOT && cpu_rw) ? rom_word : '0) |
                    ((per_sel && cpu_rw) ? per_rdata : '0);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_comb ram_bank_en[b] = ram_act && (bank_idx == BSEL_W'(b));
    end

endmodule

// File: rtl/boot_mem_decoder_chk.sv
module boot_mem_decoder_chk #(
    parameter int unsigned PER_DIV = 10
) (
    input logic        clk,
    input logic        rst_por_n,
    input logic        cpu_rst,
    input logic        cpu_req,
    input logic        cpu_ack,
    input logic [15:0] cpu_rdata,
    input logic [22:0] cpu_addr,
    input logic [1:0]  ram_bank_en,
    input logic        ram_oe,
    input logic        ram_we,
    input logic        per_sel,
    input logic        lock_w,
    input logic        overlay_w
);

    // consecutive sampled edges with a request still waiting for its acknowledge
    logic [7:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_por_n || cpu_rst)     run_q <= '0;
        else if (cpu_req && !cpu_ack)  run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
        else                           run_q <= '0;
    end

    assert_bank_onehot_R1: assert property (@(posedge clk) disable iff (!rst_por_n)
        $onehot0(ram_bank_en));

    assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_por_n)
        ram_we |=> !ram_we);

    assert_overlay_guard_R4: assert property (@(posedge clk) disable iff (!rst_por_n)
        (overlay_w && cpu_addr[22:8] == 15'd0) |-> (!ram_oe && !ram_we));

    assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_por_n)
        (lock_w && cpu_addr[22:18] == 5'h1F) |-> !ram_we);

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_por_n)
        lock_w |=> lock_w);

    assert_ack_latency_R8: assert property (@(posedge clk) disable iff (!rst_por_n || cpu_rst)
        $rose(cpu_ack) |-> (run_q == 8'd1 || run_q == 8'(PER_DIV)));

    assert_per_ram_excl_R8: assert property (@(posedge clk) disable iff (!rst_por_n)
        !(per_sel && (ram_oe || ram_we)));

    assert_single_ack_R9: assert property (@(posedge clk) disable iff (!rst_por_n)
        cpu_ack |=> !cpu_ack);

    assert_rdata_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_por_n)
        !cpu_ack |-> (cpu_rdata == 16'h0));

endmodule

bind boot_mem_decoder boot_mem_decoder_chk #(.PER_DIV(PER_DIV)) u_chk (
    .clk         (clk),
    .rst_por_n   (rst_por_n),
    .cpu_rst     (cpu_rst),
    .cpu_req     (cpu_req),
    .cpu_ack     (cpu_ack),
    .cpu_rdata   (cpu_rdata),
    .cpu_addr    (cpu_addr),
    .ram_bank_en (ram_bank_en),
    .ram_oe      (ram_oe),
    .ram_we      (ram_we),
    .per_sel     (per_sel),
    .lock_w      (lock_w),
    .overlay_w   (overlay_w)
);

// File: tb/boot_mem_decoder_tb.sv
module boot_mem_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_por_n = 1'b0;
    logic        cpu_rst = 1'b0;
    logic        ldr_lock_set = 1'b0;
    logic        ldr_boot_set = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_rw = 1'b1;
    logic        cpu_uds = 1'b0;
    logic        cpu_lds = 1'b0;
    logic [22:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic [1:0]  ram_bank_en;
    logic [18:0] ram_addr;
    logic        ram_ube, ram_lbe, ram_oe, ram_we;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic        per_sel, per_we;
    logic [15:0] per_wdata;
    logic [15:0] per_rdata = '0;

    boot_mem_decoder u_dut (
        .clk(clk), .rst_por_n(rst_por_n), .cpu_rst(cpu_rst),
        .ldr_lock_set(ldr_lock_set), .ldr_boot_set(ldr_boot_set),
        .cpu_req(cpu_req), .cpu_rw(cpu_rw), .cpu_uds(cpu_uds), .cpu_lds(cpu_lds),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .ram_bank_en(ram_bank_en), .ram_addr(ram_addr), .ram_ube(ram_ube),
        .ram_lbe(ram_lbe), .ram_oe(ram_oe), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .per_sel(per_sel), .per_we(per_we), .per_wdata(per_wdata),
        .per_rdata(per_rdata)
    );

    always #4 clk = ~clk;   // 125 MHz

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit started = 0;

    // reference state kept by the bench
    logic [15:0] sram [int];     // physical word index -> contents
    bit  m_overlay = 1;
    bit  m_lock = 0;
    bit  m_boot = 0;
    logic [15:0] per_val = 16'h5A5A;

    // pin capture of the current access
    logic        c_we, c_oe, c_ube, c_lbe, c_psel, c_pwe;
    logic [1:0]  c_bank;
    logic [18:0] c_addr;
    logic [15:0] res_rd;
    int          res_lat;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 none, 1 chip, 2 fast, 3 rom image, 4 peripheral; phys = word index
    function automatic int map_kind(input int a, output int phys);
        phys = 0;
        if (a < 'h80000) begin phys = a / 2; return 1; end
        if (a >= 'h200000 && a < 'h300000) begin phys = 'h40000 + (a - 'h200000) / 2; return 2; end
        if (a >= 'hF80000) begin phys = 'hC0000 + (a - 'hF80000) / 2; return 3; end
        if (a >= 'hBF0000 && a < 'hC00000) return 4;
        return 0;
    endfunction

    function automatic logic [15:0] exp_read(input int a);
        int p, k;
        if (m_overlay && a < 'h200) return 16'hB000 + 16'(a / 2);
        k = map_kind(a, p);
        if (k >= 1 && k <= 3) return sram.exists(p) ? sram[p] : 16'h0;
        if (k == 4) return per_val;
        return 16'h0;
    endfunction

    task automatic access(input int a, input bit rw, input bit uds, input bit lds, input logic [15:0] wd);
        int key;
        @(negedge clk);
        cpu_addr = 23'(a / 2); cpu_rw = rw; cpu_uds = uds; cpu_lds = lds;
        cpu_wdata = wd; cpu_req = 1'b1;
        #1;
        c_we = ram_we; c_oe = ram_oe; c_ube = ram_ube; c_lbe = ram_lbe;
        c_bank = ram_bank_en; c_addr = ram_addr; c_psel = per_sel; c_pwe = per_we;
        key = (c_bank == 2'b10 ? 'h80000 : 0) + int'(c_addr);
        ram_rdata = (c_oe && sram.exists(key)) ? sram[key] : 16'h0;
        per_rdata = c_psel ? per_val : 16'h0;
        res_lat = 0;
        res_rd = 16'h0;
        forever begin
            @(posedge clk);
            if (res_lat == 0 && c_we) begin
                logic [15:0] old;
                old = sram.exists(key) ? sram[key] : 16'h0;
                if (c_ube) old[15:8] = ram_wdata[15:8];
                if (c_lbe) old[7:0]  = ram_wdata[7:0];
                sram[key] = old;
            end
            res_lat++;
            @(negedge clk);
            if (cpu_ack) begin res_rd = cpu_rdata; break; end
            if (res_lat > 40) break;
        end
        cpu_req = 1'b0; ram_rdata = '0; per_rdata = '0;
        @(posedge clk);
        @(negedge clk);
        chk(cpu_ack == 1'b0, "R9 no repeated ack", 32'(cpu_ack), 0);
    endtask

    task automatic do_read(input int a, input string tag);
        logic [15:0] e;
        int p, k;
        e = exp_read(a);
        k = map_kind(a, p);
        access(a, 1'b1, 1'b1, 1'b1, 16'h0);
        chk(res_rd == e, {tag, " read data"}, 32'(res_rd), 32'(e));
        chk(res_lat == ((k == 4) ? 10 : 1), {tag, " ack latency"}, res_lat, (k == 4) ? 10 : 1);
    endtask

    task automatic do_write(input int a, input bit uds, input bit lds, input logic [15:0] wd,
                            input bit exp_we, input string tag);
        access(a, 1'b0, uds, lds, wd);
        chk(c_we == exp_we, {tag, " write enable"}, 32'(c_we), 32'(exp_we));
        chk(res_lat == 1, {tag, " write ack latency"}, res_lat, 1);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: cpu_rst = 1'b1;
            1: ldr_lock_set = 1'b1;
            2: ldr_boot_set = 1'b1;
            default: rst_por_n = 1'b0;
        endcase
        @(negedge clk);
        cpu_rst = 1'b0; ldr_lock_set = 1'b0; ldr_boot_set = 1'b0; rst_por_n = 1'b1;
        if (which == 0 && m_boot) m_overlay = 0;
        if (which == 1) m_lock = 1;
        if (which == 2) m_boot = 1;
        if (which == 3) begin m_overlay = 1; m_lock = 0; m_boot = 0; end
    endtask

    // per-clock comparison of the OR bus: no data without acknowledge
    always @(negedge clk) begin
        if (started && !done && !cpu_ack)
            chk(cpu_rdata == 16'h0, "R10 rdata zero without ack", 32'(cpu_rdata), 0);
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        sram[0] = 16'h1234;
        sram[8] = 16'h0BAD;
        repeat (3) @(negedge clk);
        rst_por_n = 1'b1;
        @(negedge clk);
        started = 1;
        chk(cpu_ack == 0 && cpu_rdata == 0, "R10 reset outputs idle", 32'(cpu_ack), 0);
        chk(ram_bank_en == 0 && !ram_we && !per_sel, "R1 reset strobes off", 32'(ram_bank_en), 0);

        // R4 overlay reads and ignored write
        do_read('h000000, "R4 boot word 0");
        chk(c_oe == 0, "R4 no ram_oe under overlay", 32'(c_oe), 0);
        do_read('h0001FE, "R4 boot last word");
        do_write('h000010, 1, 1, 16'h7777, 0, "R4 overlay write blocked");

        // R1 R3 mapping at window edges
        do_write('h000400, 1, 1, 16'hC0DE, 1, "R3 chip write");
        chk(c_bank == 2'b01 && c_addr == 19'h00200, "R1 chip bank/addr", {11'h0, c_bank, c_addr}, {11'h0, 2'b01, 19'h00200});
        do_read('h000400, "R3 chip readback");
        do_write('h2FFFFE, 1, 1, 16'hFA57, 1, "R1 fast top write");
        chk(c_bank == 2'b10 && c_addr == 19'h3FFFF, "R1 fast top bank/addr", {11'h0, c_bank, c_addr}, {11'h0, 2'b10, 19'h3FFFF});
        do_read('h2FFFFE, "R1 fast top readback");
        do_write('h200000, 1, 1, 16'h1111, 1, "R1 fast base write");
        chk(c_bank == 2'b01 && c_addr == 19'h40000, "R1 fast base bank/addr", {11'h0, c_bank, c_addr}, {11'h0, 2'b01, 19'h40000});
        do_write('hF80000, 1, 1, 16'h4B49, 1, "R1 rom image write unlocked");
        chk(c_bank == 2'b10 && c_addr == 19'h40000, "R1 rom image bank/addr", {11'h0, c_bank, c_addr}, {11'h0, 2'b10, 19'h40000});
        do_read('hF80000, "R1 rom image readback");

        // R2 byte enables
        do_write('h001000, 1, 0, 16'hABCD, 1, "R2 upper only");
        chk(c_ube == 1 && c_lbe == 0, "R2 upper strobe pins", {c_ube, c_lbe}, 2'b10);
        do_read('h001000, "R2 upper merged");
        do_write('h001000, 0, 1, 16'hFF12, 1, "R2 lower only");
        chk(c_ube == 0 && c_lbe == 1, "R2 lower strobe pins", {c_ube, c_lbe}, 2'b01);
        do_read('h001000, "R2 both bytes merged");

        // R6 write lock
        pulse(1);
        do_write('hF80000, 1, 1, 16'h9999, 0, "R6 locked write");
        do_read('hF80000, "R6 locked read unchanged");

        // R8 R9 peripheral stretch
        do_read('hBFE000, "R8 peripheral read");
        chk(c_psel == 1 && c_pwe == 0, "R8 per_sel on read", {c_psel, c_pwe}, 2'b10);
        access('hBFD000, 1'b0, 1, 1, 16'h00AA);
        chk(res_lat == 10, "R8 peripheral write latency", res_lat, 10);
        chk(c_psel == 1 && c_pwe == 1, "R8 per_we on write", {c_psel, c_pwe}, 2'b11);
        do_read('hBFFFFE, "R9 back-to-back peripheral");

        // R10 unmapped
        do_read('h800000, "R10 unmapped");
        chk(c_bank == 0 && c_oe == 0 && c_psel == 0, "R10 unmapped strobes", {c_bank, c_oe, c_psel}, 0);

        // R5 overlay removal sequence
        pulse(0);
        do_read('h000000, "R5 cpu reset before boot-done keeps overlay");
        pulse(2);
        do_read('h000000, "R5 boot-done alone keeps overlay");
        pulse(0);
        do_read('h000000, "R5 overlay removed");
        do_read('h000010, "R5 overlay write had no effect");

        // R7 persistence and power-on clear
        do_write('hF80000, 1, 1, 16'h2222, 0, "R7 lock survives cpu reset");
        do_read('hF80000, "R7 locked data kept");
        pulse(3);
        do_read('h000000, "R7 power-on restores overlay");
        pulse(0);
        do_read('h000000, "R7 boot-done cleared by power-on");
        do_write('hF80000, 1, 1, 16'h3333, 1, "R7 lock cleared by power-on");
        do_read('hF80000, "R7 unlocked readback");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule